// File: doc/BRIEF.md
# Codec Response Ring Dispatcher

This block sits on the controller side of a codec link. Each response that arrives from a codec is written into a circular buffer in system memory, where one slot of the buffer is two 32-bit words. The first word holds the response payload. The second word holds the responding codec address and a flag that marks the response as unsolicited. A write pointer shows the last slot that was completely written. Software compares that pointer with its own read pointer, which is supplied here as `rd_ptr`, to find the new slots. Memory arbitration is outside this block: `mem_we` is a plain write strobe.

The block also keeps a table of outstanding solicited commands for each codec. A pulse on `cmd_issue` adds one to the count of the addressed codec. Every accepted response is classified in one of three ways:
- **Solicited**: the count drops by one and the payload is stored as that codec's latest result.
- **Unsolicited**: the counts are left alone and an event flag is raised.
- **Spurious**: the codec address is out of range, or a solicited response arrives while its codec's count is zero. A sticky flag is raised.

Every accepted response is written to the ring, whatever its class. Interrupts are raised after a programmable number of written slots.

The write sequencer has three states:
- `ST_IDLE`: waits for a response. On accept it moves to `ST_WORD0`, or stays in `ST_IDLE` when the ring is full and the response is dropped.
- `ST_WORD0`: writes the payload word and always moves to `ST_WORD1`.
- `ST_WORD1`: writes the extended word, publishes the write pointer and returns to `ST_IDLE`.

Top module: `resp_ring_dispatch`

## Requirements
- R1: An entry is written as two consecutive write cycles to the same slot. The payload goes to word address `{slot,0}` in the first cycle and the extended word goes to `{slot,1}` in the second.
- R2: The extended word carries the codec address in bits [3:0] and the unsolicited flag in bit 4. All other bits are zero.
- R3: A new entry goes to slot `wr_ptr+1`, taken modulo 256. `wr_ptr` takes that slot value only after both words are written, so the slot after 255 is 0.
- R4: A response whose codec address is NUM_CODEC or higher is spurious. It sets status bit 3, does not set bit 2, and touches no counter.
- R5: `cmd_issue` increments the addressed codec's counter, which saturates at its maximum. A counted solicited response decrements it. When both happen in the same cycle for the same codec, the counter is unchanged.
- R6: A solicited response is classified against the counter value before the current cycle. If that value is zero, the response is spurious: it sets status bit 3 and leaves the counter and the stored result unchanged. Otherwise its payload becomes the codec's result, which is read out through `res_sel`/`res_data`.
- R7: An unsolicited response from a valid codec sets status bit 2. It leaves all counters and results unchanged.
- R8: Every completed entry advances an entry count. When the count reaches `irq_thresh`, status bit 0 is set and the count restarts. A threshold of 0 acts as 1.
- R9: `irq` equals status bit 0 gated by `irq_en`, and it stays high until bit 0 is cleared.
- R10: A pulse on `wp_reset` sets `wr_ptr` to 0 on the next edge, so the next entry goes to slot 1. No response is accepted in that cycle.
- R11: A response accepted while `wr_ptr+1 == rd_ptr` is dropped. Nothing is written, `wr_ptr` is unchanged, status bit 1 is set, and counters, results and the entry count are unchanged.
- R12: While `dma_en` is low, `rsp_ready` is low and no entry is written.
- R13: Status bits are sticky. A 1 in bit i of `clr_status` clears status bit i. If a bit is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | Enables acceptance and ring writes |
| irq_en | input | 1 | Interrupt output enable |
| wp_reset | input | 1 | Pulse that returns the write pointer to 0 |
| irq_thresh | input | 8 | Number of entries per interrupt |
| rd_ptr | input | 8 | Software read pointer, used for the full test |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Response accepted this cycle when valid |
| rsp_data | input | 32 | Response payload |
| rsp_codec | input | 4 | Responding codec address |
| rsp_unsol | input | 1 | Response is unsolicited |
| cmd_issue | input | 1 | A command was queued |
| cmd_codec | input | 4 | Codec address of the queued command |
| mem_we | output | 1 | Ring word write strobe |
| mem_addr | output | 9 | Ring word address, `{slot, word}` |
| mem_wdata | output | 32 | Ring word data |
| wr_ptr | output | 8 | Last completed slot |
| clr_status | input | 4 | Write-one-to-clear of the status bits |
| status | output | 4 | {spurious, event, overrun, interrupt} |
| irq | output | 1 | Response interrupt |
| res_sel | input | 4 | Codec selected for readout |
| res_data | output | 32 | Latest result of the selected codec |
| res_pend | output | 4 | Outstanding count of the selected codec |

## Verification
Command issue and response retirement can land on the same codec's counter in the same cycle. The bench pulses `cmd_issue` in the cycle a solicited response for the same codec is accepted. For a counter of one, the count must be unchanged afterwards and the result must be updated. For a counter of zero, the response must be flagged spurious and the count must end at one, because classification uses the value before the cycle. A scoreboard queue holds every expected ring word, including the wrap from slot 255 to 0. A dropped entry must leave the queue untouched.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
    localparam int CODEC_W = 4;
    localparam int NSTAT   = 4;
    localparam int ST_IRQ  = 0;
    localparam int ST_OVR  = 1;
    localparam int ST_EVT  = 2;
    localparam int ST_SPUR = 3;

    typedef enum logic [1:0] {ST_IDLE, ST_WORD0, ST_WORD1} ring_state_e;

    typedef struct packed {
        logic [31:0]        data;
        logic [CODEC_W-1:0] codec;
        logic               unsol;
    } rsp_t;

    function automatic logic [31:0] ext_word(input rsp_t r);
        return {{(31 - CODEC_W){1'b0}}, r.unsol, r.codec};
    endfunction
endpackage

// File: rtl/rrd_pend_table.sv
module rrd_pend_table
    import rrd_pkg::*;
#(
    parameter int NUM_CODEC = 4,
    parameter int CNT_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  rsp_t               rsp,
    input  logic               cmd_issue,
    input  logic [CODEC_W-1:0] cmd_codec,
    input  logic [CODEC_W-1:0] res_sel,
    output logic               is_spur,
    output logic               is_event,
    output logic [31:0]        res_data,
    output logic [CNT_W-1:0]   res_pend
);
    logic [CNT_W-1:0] cnt_arr [NUM_CODEC];
    logic [31:0]      res_arr [NUM_CODEC];
    logic             addr_ok;
    logic [CNT_W-1:0] cur_cnt;

    always_comb begin
        addr_ok = {1'b0, rsp.codec} < (CODEC_W + 1)'(NUM_CODEC);
        cur_cnt = '0;
        for (int i = 0; i < NUM_CODEC; i++)
            if (rsp.codec == CODEC_W'(i)) cur_cnt = cnt_arr[i];
        is_spur  = !addr_ok || (!rsp.unsol && cur_cnt == '0);
        is_event = addr_ok && rsp.unsol;
    end

    always_comb begin
        res_data = '0;
        res_pend = '0;
        for (int i = 0; i < NUM_CODEC; i++)
            if (res_sel == CODEC_W'(i)) begin
                res_data = res_arr[i];
                res_pend = cnt_arr[i];
            end
    end

    for (genvar g = 0; g < NUM_CODEC; g++) begin : g_codec
        logic [CNT_W-1:0] cnt_q;
        logic [31:0]      res_q;
        logic             inc, dec;

        assign inc = cmd_issue && cmd_codec == CODEC_W'(g);
        assign dec = take && !is_spur && !rsp.unsol && rsp.codec == CODEC_W'(g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
                res_q <= '0;
            end else begin
                if (inc && !dec && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
                else if (dec && !inc)           cnt_q <= cnt_q - 1'b1;
                if (dec) res_q <= rsp.data;
            end
        end

        assign cnt_arr[g] = cnt_q;
        assign res_arr[g] = res_q;
    end
endmodule

// File: rtl/rrd_ring_fsm.sv
module rrd_ring_fsm
    import rrd_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dma_en,
    input  logic          wp_reset,
    input  logic [AW-1:0] rd_ptr,
    input  logic          rsp_valid,
    input  rsp_t          rsp,
    output logic          rsp_ready,
    output logic          take,
    output logic          drop,
    output logic          done,
    output logic          mem_we,
    output logic [AW:0]   mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [AW-1:0] wr_ptr
);
    ring_state_e   state, state_nx;
    rsp_t          rsp_q;
    logic [AW-1:0] slot_q, next_slot;
    logic          full;

    assign next_slot = AW'(wr_ptr + 1'b1);
    assign full      = next_slot == rd_ptr;
    assign take      = rsp_valid && rsp_ready && !full;
    assign drop      = rsp_valid && rsp_ready && full;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (take) state_nx = ST_WORD0;
            ST_WORD0: state_nx = ST_WORD1;
            ST_WORD1: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q  <= '0;
            slot_q <= '0;
            wr_ptr <= '0;
        end else begin
            if (take) begin
                rsp_q  <= rsp;
                slot_q <= next_slot;
            end
            if (wp_reset)               wr_ptr <= '0;
            else if (state == ST_WORD1) wr_ptr <= slot_q;
        end
    end

    always_comb begin
        rsp_ready = 1'b0;
        done      = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_IDLE:  rsp_ready = dma_en && !wp_reset;
            ST_WORD0: begin
                mem_we    = 1'b1;
                mem_addr  = {slot_q, 1'b0};
                mem_wdata = rsp_q.data;
            end
            ST_WORD1: begin
                mem_we    = 1'b1;
                done      = 1'b1;
                mem_addr  = {slot_q, 1'b1};
                mem_wdata = ext_word(rsp_q);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rrd_status.sv
module rrd_status
    import rrd_pkg::*;
#(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             set_ovr,
    input  logic             set_evt,
    input  logic             set_spur,
    input  logic [NSTAT-1:0] clr,
    input  logic [THR_W-1:0] irq_thresh,
    input  logic             irq_en,
    output logic [NSTAT-1:0] status,
    output logic             irq
);
    logic [THR_W-1:0] ent_cnt;
    logic [THR_W:0]   cnt_inc, thr_eff;
    logic             irq_hit;
    logic [NSTAT-1:0] set_v;

    always_comb begin
        cnt_inc = {1'b0, ent_cnt} + 1'b1;
        thr_eff = (irq_thresh == '0) ? (THR_W + 1)'(1) : {1'b0, irq_thresh};
        irq_hit = done && (cnt_inc >= thr_eff);
        set_v          = '0;
        set_v[ST_IRQ]  = irq_hit;
        set_v[ST_OVR]  = set_ovr;
        set_v[ST_EVT]  = set_evt;
        set_v[ST_SPUR] = set_spur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_cnt <= '0;
            status  <= '0;
        end else begin
            if (irq_hit)   ent_cnt <= '0;
            else if (done) ent_cnt <= cnt_inc[THR_W-1:0];
            status <= set_v | (status & ~clr);
        end
    end

    assign irq = status[ST_IRQ] && irq_en;
endmodule

// File: rtl/resp_ring_dispatch.sv
module resp_ring_dispatch
    import rrd_pkg::*;
#(
    parameter int NUM_CODEC = 4,
    parameter int CNT_W     = 4,
    parameter int AW        = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dma_en,
    input  logic               irq_en,
    input  logic               wp_reset,
    input  logic [AW-1:0]      irq_thresh,
    input  logic [AW-1:0]      rd_ptr,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [31:0]        rsp_data,
    input  logic [CODEC_W-1:0] rsp_codec,
    input  logic               rsp_unsol,
    input  logic               cmd_issue,
    input  logic [CODEC_W-1:0] cmd_codec,
    output logic               mem_we,
    output logic [AW:0]        mem_addr,
    output logic [31:0]        mem_wdata,
    output logic [AW-1:0]      wr_ptr,
    input  logic [NSTAT-1:0]   clr_status,
    output logic [NSTAT-1:0]   status,
    output logic               irq,
    input  logic [CODEC_W-1:0] res_sel,
    output logic [31:0]        res_data,
    output logic [CNT_W-1:0]   res_pend
);
    rsp_t rsp;
    logic take, drop, done, is_spur, is_event;

    assign rsp = '{data: rsp_data, codec: rsp_codec, unsol: rsp_unsol};

    rrd_ring_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .wp_reset(wp_reset),
        .rd_ptr(rd_ptr), .rsp_valid(rsp_valid), .rsp(rsp),
        .rsp_ready(rsp_ready), .take(take), .drop(drop), .done(done),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wr_ptr(wr_ptr)
    );

    rrd_pend_table #(.NUM_CODEC(NUM_CODEC), .CNT_W(CNT_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .take(take), .rsp(rsp),
        .cmd_issue(cmd_issue), .cmd_codec(cmd_codec), .res_sel(res_sel),
        .is_spur(is_spur), .is_event(is_event),
        .res_data(res_data), .res_pend(res_pend)
    );

    rrd_status #(.THR_W(AW)) u_stat (
        .clk(clk), .rst_n(rst_n), .done(done), .set_ovr(drop),
        .set_evt(take && is_event), .set_spur(take && is_spur),
        .clr(clr_status), .irq_thresh(irq_thresh), .irq_en(irq_en),
        .status(status), .irq(irq)
    );
endmodule

// File: rtl/rrd_checker.sv
module rrd_checker #(
    parameter int NUM_CODEC = 4,
    parameter int CNT_W     = 4,
    parameter int AW        = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dma_en,
    input logic             irq_en,
    input logic             wp_reset,
    input logic [AW-1:0]    rd_ptr,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [3:0]       rsp_codec,
    input logic             rsp_unsol,
    input logic             cmd_issue,
    input logic [3:0]       cmd_codec,
    input logic             mem_we,
    input logic [AW:0]      mem_addr,
    input logic [31:0]      mem_wdata,
    input logic [AW-1:0]    wr_ptr,
    input logic [3:0]       clr_status,
    input logic [3:0]       status,
    input logic             irq,
    input logic [3:0]       res_sel,
    input logic [CNT_W-1:0] res_pend
);
    logic accept, full, codec_ok;
    assign accept   = rsp_valid && rsp_ready;
    assign full     = AW'(wr_ptr + 1'b1) == rd_ptr;
    assign codec_ok = {1'b0, rsp_codec} < 5'(NUM_CODEC);

    p_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_addr[0]) |=> (mem_we && mem_addr == $past(mem_addr) + 1'b1));

    p_ext_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr[0]) |-> (mem_wdata[31:5] == '0));

    p_slot_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_addr[0]) |-> (mem_addr[AW:1] == AW'(wr_ptr + 1'b1)));

    p_bad_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !full && !codec_ok && !clr_status[3]) |=> status[3]);

    p_cmd_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && !rsp_valid && cmd_codec == res_sel && res_pend != '1
         && {1'b0, cmd_codec} < 5'(NUM_CODEC))
        |=> (!$stable(res_sel) || res_pend == $past(res_pend) + 1'b1));

    p_zero_spur_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !full && !rsp_unsol && rsp_codec == res_sel && codec_ok
         && res_pend == '0 && !clr_status[3]) |=> status[3]);

    p_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !full && rsp_unsol && codec_ok && !clr_status[2]) |=> status[2]);

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_status[0] && irq_en) |=> irq);

    p_wp_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wp_reset |=> (wr_ptr == '0));

    p_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && full && !clr_status[1]) |=> (!mem_we && status[1]));

    p_dma_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !rsp_ready);
endmodule

bind resp_ring_dispatch rrd_checker #(
    .NUM_CODEC(NUM_CODEC), .CNT_W(CNT_W), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .irq_en(irq_en),
    .wp_reset(wp_reset), .rd_ptr(rd_ptr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_codec(rsp_codec), .rsp_unsol(rsp_unsol),
    .cmd_issue(cmd_issue), .cmd_codec(cmd_codec), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wr_ptr(wr_ptr),
    .clr_status(clr_status), .status(status), .irq(irq),
    .res_sel(res_sel), .res_pend(res_pend)
);

// File: tb/sim_resp_ring_dispatch.sv
module sim_resp_ring_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_en = 1'b0, irq_en = 1'b0, wp_reset = 1'b0;
    logic [7:0]  irq_thresh = 8'd1, rd_ptr = 8'd0;
    logic        rsp_valid = 1'b0, rsp_unsol = 1'b0, cmd_issue = 1'b0;
    logic [31:0] rsp_data = '0;
    logic [3:0]  rsp_codec = '0, cmd_codec = '0, clr_status = '0, res_sel = '0;
    logic        rsp_ready, mem_we, irq;
    logic [8:0]  mem_addr;
    logic [31:0] mem_wdata, res_data;
    logic [7:0]  wr_ptr;
    logic [3:0]  status, res_pend;

    int checks = 0;
    int errors = 0;
    logic [7:0]  exp_wp = 8'd0;
    logic [40:0] exp_q[$];

    always #4 clk = ~clk;

    resp_ring_dispatch u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected ring words (R1 R2 R3)
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected write actual=%0h expected=none", {mem_addr, mem_wdata});
            end else begin
                logic [40:0] e;
                e = exp_q.pop_front();
                if (e != {mem_addr, mem_wdata}) begin
                    errors++;
                    $display("FAIL R1 R2 R3 ring word actual=%0h expected=%0h", {mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    task automatic send(input logic [3:0] c, input logic u, input logic [31:0] d,
                        input bit dropped, input bit with_cmd, input logic [3:0] cc);
        if (!dropped) begin
            exp_wp = exp_wp + 8'd1;
            exp_q.push_back({exp_wp, 1'b0, d});
            exp_q.push_back({exp_wp, 1'b1, 27'd0, u, c});
        end
        @(negedge clk);
        rsp_valid = 1'b1; rsp_codec = c; rsp_unsol = u; rsp_data = d;
        cmd_issue = with_cmd; cmd_codec = cc;
        @(negedge clk);
        rsp_valid = 1'b0; cmd_issue = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cmd(input logic [3:0] c);
        @(negedge clk); cmd_issue = 1'b1; cmd_codec = c;
        @(negedge clk); cmd_issue = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk); clr_status = 4'hF;
        @(negedge clk); clr_status = 4'h0;
    endtask

    task automatic peek(input logic [3:0] c);
        res_sel = c; #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_ptr == 0, "R3 reset wr_ptr", wr_ptr, 0);
        chk(status == 0 && irq == 0, "R13 reset status", status, 0);
        chk(rsp_ready == 0, "R12 ready with dma off", rsp_ready, 0);
        // R12: a response while dma is off writes nothing
        rsp_valid = 1'b1; rsp_data = 32'hDEAD;
        repeat (2) @(negedge clk);
        rsp_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(wr_ptr == 0 && exp_q.size() == 0, "R12 no entry with dma off", wr_ptr, 0);

        dma_en = 1'b1; irq_en = 1'b1; irq_thresh = 8'd1;
        cmd(4'd1); peek(4'd1);
        chk(res_pend == 1, "R5 count after command", res_pend, 1);
        send(4'd1, 1'b0, 32'hA1A1_0001, 0, 0, 0);
        peek(4'd1);
        chk(wr_ptr == 1, "R3 wr_ptr after entry", wr_ptr, 1);
        chk(res_pend == 0 && res_data == 32'hA1A1_0001, "R6 solicited result", res_data, 32'hA1A1_0001);
        chk(irq == 1 && status[0], "R8 irq per entry", {status, irq}, 5'b00011);
        clear_all();
        chk(irq == 0 && status == 0, "R13 clear", status, 0);

        send(4'd2, 1'b0, 32'hB2, 0, 0, 0); peek(4'd2);
        chk(status[3] == 1, "R6 zero count spurious", status, 4'b1001);
        chk(res_pend == 0 && res_data == 0, "R6 counter and result kept", res_data, 0);
        clear_all();

        send(4'd6, 1'b1, 32'hC3, 0, 0, 0);
        chk(status[3] == 1 && status[2] == 0, "R4 bad address", status, 4'b1001);
        clear_all();

        cmd(4'd0);
        send(4'd0, 1'b1, 32'hD4, 0, 0, 0); peek(4'd0);
        chk(status[2] == 1 && status[3] == 0, "R7 event flag", status, 4'b0101);
        chk(res_pend == 1 && res_data == 0, "R7 counters bypassed", res_pend, 1);
        send(4'd0, 1'b0, 32'hE5, 0, 0, 0); peek(4'd0);
        chk(res_pend == 0 && res_data == 32'hE5, "R6 result after event", res_data, 32'hE5);
        clear_all();

        cmd(4'd3);
        send(4'd3, 1'b0, 32'hF6, 0, 1, 4'd3); peek(4'd3);
        chk(res_pend == 1 && res_data == 32'hF6, "R5 same-cycle inc and dec", res_pend, 1);
        send(4'd2, 1'b0, 32'h77, 0, 1, 4'd2); peek(4'd2);
        chk(res_pend == 1 && status[3] == 1, "R6 spurious with same-cycle command", {status, res_pend}, 8'h91);
        send(4'd2, 1'b0, 32'h88, 0, 0, 0); peek(4'd2);
        chk(res_pend == 0 && res_data == 32'h88, "R5 decrement", res_data, 32'h88);
        clear_all();

        irq_thresh = 8'd3;
        send(4'd0, 1'b1, 32'h1, 0, 0, 0);
        send(4'd0, 1'b1, 32'h2, 0, 0, 0);
        chk(irq == 0, "R8 below threshold", irq, 0);
        send(4'd0, 1'b1, 32'h3, 0, 0, 0);
        chk(irq == 1, "R8 threshold reached", irq, 1);
        clear_all();
        irq_en = 1'b0; irq_thresh = 8'd0;
        send(4'd0, 1'b1, 32'h4, 0, 0, 0);
        chk(status[0] == 1 && irq == 0, "R9 masked irq", {status, irq}, 5'b01010);
        irq_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(irq == 1, "R9 irq held until clear", irq, 1);
        clear_all();

        @(negedge clk); wp_reset = 1'b1;
        @(negedge clk); wp_reset = 1'b0;
        chk(wr_ptr == 0, "R10 pointer reset", wr_ptr, 0);
        exp_wp = 8'd0;
        send(4'd0, 1'b1, 32'h55, 0, 0, 0);
        chk(wr_ptr == 1, "R10 next slot is 1", wr_ptr, 1);

        cmd(4'd2);
        rd_ptr = exp_wp + 8'd1;
        send(4'd2, 1'b0, 32'h99, 1, 0, 0); peek(4'd2);
        chk(wr_ptr == exp_wp && status[1] == 1, "R11 overrun drop", {status, wr_ptr}, {4'b0010, exp_wp});
        chk(res_pend == 1 && res_data == 32'h88, "R11 counters untouched", res_pend, 1);
        rd_ptr = 8'd0;
        send(4'd2, 1'b0, 32'hAA, 0, 0, 0); peek(4'd2);
        chk(res_pend == 0 && res_data == 32'hAA, "R11 accepted after room", res_data, 32'hAA);
        clear_all();

        // R3 wrap from slot 255 to slot 0
        irq_thresh = 8'd1;
        while (exp_wp != 8'd255) begin
            rd_ptr = exp_wp;
            send(4'd1, 1'b1, {24'h0, exp_wp}, 0, 0, 0);
        end
        chk(wr_ptr == 8'd255, "R3 slot 255", wr_ptr, 255);
        rd_ptr = 8'd255;
        send(4'd1, 1'b1, 32'h5A5A, 0, 0, 0);
        chk(wr_ptr == 8'd0, "R3 wrap to 0", wr_ptr, 0);
        chk(exp_q.size() == 0, "R1 all words written", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule